// File: doc/BRIEF.md
# Kickstart and Wakeup Power Controller

This block sits in the always-on domain of a battery-backed timekeeper. It watches three event sources: an active-low kickstart input, an active-low RAM-clear input and a wakeup-alarm match pulse from the alarm comparator. Each event is held in a sticky flag until software clears it. A kickstart event also raises a power-on request. That request drives an active-low open-drain pin, and the pin is modelled here as a drive-enable.

Software reaches the block through a byte-wide port that selects one of two registers. The status register holds the three flags, the power-active bit and two live status inputs. The configuration register holds three interrupt enables, the RAM-clear edge enable and the bit that chooses how the power-on output behaves during a power failure. The enabled flags are combined into a single interrupt request.

Both asynchronous inputs pass through a synchronizer of `SYNC_STAGES` flops. A falling edge is detected after the synchronizer. The alarm match is already synchronous and is taken directly.

Top module: `pwr_event_ctl`

## Requirements
- R1: A falling edge on `kick_n` sets status bit 0 (kick flag) and asserts `pwr_req_drive`. Both become visible exactly `SYNC_STAGES`+1 rising clock edges after the input falls, and are not visible one edge earlier.
- R2: A falling edge on `ram_clr_n` sets status bit 2 (RAM-clear flag) only while configuration bit 4 (RAM-clear edge enable) is 1. When that bit is 0 the edge is ignored.
- R3: `wake_hit` high at a rising clock edge sets status bit 1 (wake flag) at that edge.
- R4: The flags in status bits 2:0 are sticky. A status write with a 0 in a flag bit clears that flag, and a 1 leaves it unchanged. An event arriving in the same cycle as a clearing write leaves the flag set.
- R5: Status bit 3 reads 0 while `pwr_req_drive` is 1 and reads 1 otherwise. Writing 1 to status bit 3 withdraws the power-on request. Writing 0 to it has no effect.
- R6: While `pwr_fail` is 1 and configuration bit 3 (hold-on-fail) is 0, `pwr_req_drive` is 0, but the request is retained and drives again once `pwr_fail` falls. With configuration bit 3 at 1, `pwr_fail` does not affect the output.
- R7: `irq_req` is 1 exactly when a flag is set whose enable is 1. The enables are configuration bit 0 (kick), bit 1 (wake) and bit 2 (RAM-clear).
- R8: Status bit 7 follows `aux_batt_ok` and status bit 6 follows `incr_busy`. Writes to these bits are ignored. Status bits 5:4 and configuration bits 7:5 always read 0.
- R9: After reset, the status register reads {aux_batt_ok, incr_busy, 6'b001000}, the configuration register reads 0, and `pwr_req_drive` and `irq_req` are 0.
- R10: An input held low produces one event only. After its flag is cleared, the flag stays clear for as long as the input remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | Register select: 0 status, 1 configuration |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| kick_n | input | 1 | Asynchronous active-low kickstart input |
| ram_clr_n | input | 1 | Asynchronous active-low RAM-clear input |
| wake_hit | input | 1 | Synchronous wakeup-alarm match |
| aux_batt_ok | input | 1 | Auxiliary battery good status |
| incr_busy | input | 1 | Time increment in progress status |
| pwr_fail | input | 1 | System power failure indication |
| pwr_req_drive | output | 1 | 1 = pull the power-on pin low |
| irq_req | output | 1 | Combined interrupt request, active high |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default 2. The expected edge-to-flag latency is derived from that parameter, so the check that the flag is absent one edge early and present on time fails if any synchronizer stage is dropped or added. With three stages, a kickstart that coincides with register writes, power-fail changes and clearing writes can also be placed on cycles the default build would not separate.

// File: rtl/pwr_event_pkg.sv
package pwr_event_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_SRC  = 3;
    localparam int CFG_W    = 5;

    // Flag index doubles as bit position in the status register and
    // as the matching interrupt-enable position in the config register.
    localparam int SRC_KICK = 0;
    localparam int SRC_WAKE = 1;
    localparam int SRC_RCLR = 2;

    localparam int ST_PACT  = 3;
    localparam int ST_INCR  = 6;
    localparam int ST_AUX   = 7;

    localparam int CF_HOLD  = 3;
    localparam int CF_RCEN  = 4;

    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_CONFIG = 1'b1;

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
        logic               req;
        logic [CFG_W-1:0]   cfg;
    } ctl_state_t;
endpackage

// File: rtl/pwr_edge_sync.sv
module pwr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
    assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

    // R10: a held-low input yields a single-cycle edge pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/pwr_ctl_core.sv
module pwr_ctl_core
    import pwr_event_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             kick_fall,
    input  logic             rclr_fall,
    input  logic             wake_hit,
    input  logic             aux_batt_ok,
    input  logic             incr_busy,
    input  logic             pwr_fail,
    output logic             pwr_req_drive,
    output logic             irq_req
);
    ctl_state_t st_d, st_q;
    logic [NUM_SRC-1:0] evt;
    logic wr_status, wr_config;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_W-1:ST_PACT+1];

    assign wr_status = reg_wr && (reg_sel == SEL_STATUS);
    assign wr_config = reg_wr && (reg_sel == SEL_CONFIG);

    always_comb begin
        evt            = '0;
        evt[SRC_KICK]  = kick_fall;
        evt[SRC_WAKE]  = wake_hit;
        evt[SRC_RCLR]  = rclr_fall & st_q.cfg[CF_RCEN];

        st_d = st_q;
        if (wr_status) begin
            st_d.flag = st_q.flag & reg_wdata[NUM_SRC-1:0];
            if (reg_wdata[ST_PACT]) st_d.req = 1'b0;
        end
        if (wr_config) st_d.cfg = reg_wdata[CFG_W-1:0];
        // events take precedence over a clearing write in the same cycle
        st_d.flag = st_d.flag | evt;
        if (kick_fall) st_d.req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwr_req_drive = st_q.req & (~pwr_fail | st_q.cfg[CF_HOLD]);
    assign irq_req       = |(st_q.flag & st_q.cfg[NUM_SRC-1:0]);

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_STATUS) begin
            reg_rdata[NUM_SRC-1:0] = st_q.flag;
            reg_rdata[ST_PACT]     = ~pwr_req_drive;
            reg_rdata[ST_INCR]     = incr_busy;
            reg_rdata[ST_AUX]      = aux_batt_ok;
        end else begin
            reg_rdata[CFG_W-1:0]   = st_q.cfg;
        end
    end

    // R1: a detected kickstart edge sets its flag and the power request
    a_r1_kick_sets: assert property (@(posedge clk) disable iff (!rst_n)
        kick_fall |=> (st_q.flag[SRC_KICK] && st_q.req));

    // R2: a RAM-clear edge with the edge enable off leaves the flag clear
    a_r2_rclr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (rclr_fall && !st_q.cfg[CF_RCEN] && !st_q.flag[SRC_RCLR]) |=> !st_q.flag[SRC_RCLR]);

    // R4: a set wake flag survives anything but a clearing write
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag[SRC_WAKE] && !(wr_status && !reg_wdata[SRC_WAKE])) |=> st_q.flag[SRC_WAKE]);

    // R5: the request persists until software writes the release bit
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && !(wr_status && reg_wdata[ST_PACT])) |=> st_q.req);

    // R7: no flags set means no interrupt
    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag == '0) |-> !irq_req);
endmodule

// File: rtl/pwr_event_ctl.sv
module pwr_event_ctl
    import pwr_event_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             kick_n,
    input  logic             ram_clr_n,
    input  logic             wake_hit,
    input  logic             aux_batt_ok,
    input  logic             incr_busy,
    input  logic             pwr_fail,
    output logic             pwr_req_drive,
    output logic             irq_req
);
    localparam int NUM_ASYNC = 2;

    logic [NUM_ASYNC-1:0] async_pins;
    logic [NUM_ASYNC-1:0] falls;

    assign async_pins = {ram_clr_n, kick_n};

    for (genvar i = 0; i < NUM_ASYNC; i++) begin : g_sync
        pwr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (async_pins[i]),
            .fall_o   (falls[i])
        );
    end

    pwr_ctl_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .kick_fall     (falls[0]),
        .rclr_fall     (falls[1]),
        .wake_hit      (wake_hit),
        .aux_batt_ok   (aux_batt_ok),
        .incr_busy     (incr_busy),
        .pwr_fail      (pwr_fail),
        .pwr_req_drive (pwr_req_drive),
        .irq_req       (irq_req)
    );
endmodule

// File: tb/pwr_event_ctl_bench.sv
module pwr_event_ctl_bench;
    localparam int NSYNC = 3;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, reg_sel = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic kick_n = 1, ram_clr_n = 1, wake_hit = 0;
    logic aux_batt_ok = 0, incr_busy = 0, pwr_fail = 0;
    logic pwr_req_drive, irq_req;

    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    pwr_event_ctl #(.SYNC_STAGES(NSYNC)) u_pwr_event_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .kick_n(kick_n),
        .ram_clr_n(ram_clr_n), .wake_hit(wake_hit), .aux_batt_ok(aux_batt_ok),
        .incr_busy(incr_busy), .pwr_fail(pwr_fail),
        .pwr_req_drive(pwr_req_drive), .irq_req(irq_req));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = s; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic rd(input logic s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s; #1;
        v = reg_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(0, v); chk("R9 status", v, 8'h08);
        rd(1, v); chk("R9 config", v, 8'h00);
        chk("R9 drive", {7'd0, pwr_req_drive}, 8'd0);
        chk("R9 irq", {7'd0, irq_req}, 8'd0);
    endtask

    task automatic t_status;
        logic [7:0] v;
        aux_batt_ok = 1; incr_busy = 1;
        rd(0, v); chk("R8 live status", v, 8'hC8);
        wr(0, 8'hF0);
        rd(0, v); chk("R8 status write ignored", v, 8'hC8);
        wr(1, 8'hE0);
        rd(1, v); chk("R8 config reserved", v, 8'h00);
        aux_batt_ok = 0; incr_busy = 0;
    endtask

    task automatic t_kick;
        logic [7:0] v;
        @(negedge clk); kick_n = 0;
        cyc(NSYNC);
        chk("R1 not early", {7'd0, pwr_req_drive}, 8'd0);
        cyc(1);
        chk("R1 drive", {7'd0, pwr_req_drive}, 8'd1);
        rd(0, v); chk("R1 flag and R5 pact low", v, 8'h01);
        @(negedge clk); kick_n = 1;
        cyc(NSYNC + 2);
    endtask

    task automatic t_level;
        logic [7:0] v;
        @(negedge clk); kick_n = 0;
        cyc(NSYNC + 2);
        wr(0, 8'h00);
        cyc(10);
        rd(0, v); chk("R10 held low no refire", v & 8'h07, 8'h00);
        @(negedge clk); kick_n = 1;
        cyc(NSYNC + 2);
    endtask

    task automatic t_pab;
        logic [7:0] v;
        wr(0, 8'h07);
        chk("R5 write 0 keeps drive", {7'd0, pwr_req_drive}, 8'd1);
        wr(0, 8'h08);
        chk("R5 release", {7'd0, pwr_req_drive}, 8'd0);
        rd(0, v); chk("R5 pact high", v, 8'h08);
        wr(0, 8'h00);
        chk("R5 write 0 no request", {7'd0, pwr_req_drive}, 8'd0);
    endtask

    task automatic t_sticky;
        logic [7:0] v;
        @(negedge clk); wake_hit = 1;
        @(negedge clk); wake_hit = 0;
        rd(0, v); chk("R3 wake flag", v, 8'h0A);
        wr(0, 8'hFF);
        rd(0, v); chk("R4 write 1 keeps", v, 8'h0A);
        wr(0, 8'h0D);
        rd(0, v); chk("R4 write 0 clears", v, 8'h08);
        @(negedge clk);
        wake_hit = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 8'h00;
        @(posedge clk); #1;
        wake_hit = 0; reg_wr = 0;
        rd(0, v); chk("R4 event beats clear", v, 8'h0A);
        wr(0, 8'h00);
    endtask

    task automatic t_rclr;
        logic [7:0] v;
        wr(1, 8'h00);
        @(negedge clk); ram_clr_n = 0;
        cyc(NSYNC + 3);
        rd(0, v); chk("R2 disabled ignored", v, 8'h08);
        @(negedge clk); ram_clr_n = 1;
        cyc(NSYNC + 2);
        wr(1, 8'h10);
        @(negedge clk); ram_clr_n = 0;
        cyc(NSYNC + 3);
        rd(0, v); chk("R2 enabled sets", v, 8'h0C);
        @(negedge clk); ram_clr_n = 1;
        cyc(NSYNC + 2);
    endtask

    task automatic t_irq;
        chk("R7 rclr not enabled", {7'd0, irq_req}, 8'd0);
        wr(1, 8'h14);
        chk("R7 rclr enabled", {7'd0, irq_req}, 8'd1);
        wr(0, 8'h00);
        chk("R7 cleared", {7'd0, irq_req}, 8'd0);
        wr(1, 8'h12);
        @(negedge clk); wake_hit = 1;
        @(negedge clk); wake_hit = 0;
        chk("R7 wake enabled", {7'd0, irq_req}, 8'd1);
        wr(1, 8'h11);
        chk("R7 wake enable off", {7'd0, irq_req}, 8'd0);
        @(negedge clk); kick_n = 0;
        cyc(NSYNC + 1);
        chk("R7 kick enabled", {7'd0, irq_req}, 8'd1);
        @(negedge clk); kick_n = 1;
        cyc(NSYNC + 2);
    endtask

    task automatic t_pfail;
        logic [7:0] v;
        wr(1, 8'h00);
        @(negedge clk); pwr_fail = 1; #1;
        chk("R6 float on fail", {7'd0, pwr_req_drive}, 8'd0);
        rd(0, v); chk("R6 pact reads high", v & 8'h08, 8'h08);
        @(negedge clk); pwr_fail = 0; #1;
        chk("R6 request retained", {7'd0, pwr_req_drive}, 8'd1);
        wr(1, 8'h08);
        @(negedge clk); pwr_fail = 1; #1;
        chk("R6 hold on fail", {7'd0, pwr_req_drive}, 8'd1);
        @(negedge clk); pwr_fail = 0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_status();
        t_kick();
        t_level();
        t_pab();
        t_sticky();
        t_rclr();
        t_irq();
        t_pfail();
        finish_run();
    end
endmodule